// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO

This block is a single-clock first-in first-out buffer for 18-bit words whose storage depth is a parameter (256 words by default). It runs in one of two timing modes. The mode is taken from a select input while reset is held and does not change until the next reset. In standard mode the read port is a plain registered output: a stored word moves onto the output register only when a read is requested. In fall-through mode the head word is moved onto the output register without any request, and a read request only advances to the next word.

The two modes share one storage array and one pointer/count pair, but they differ in capacity and in the meaning and polarity of the two boundary flags. In standard mode the flags are an active-low full indication and an active-low empty indication. In fall-through mode the output register counts as one extra storage stage, so the buffer holds one word more than the array. Its flags are an input-not-ready indication, high when no write can be taken, and an output-not-valid indication, high when the output register holds no word. A write is taken when write enable is high and the buffer is not full. A read is taken when read enable is high and the buffer holds a word. Requests that cannot be taken are dropped with no side effects.

Top module: `dual_mode_fifo`

## Requirements
- R1: `mode_sel` is sampled only on clock edges where `rst` is high (0 = standard, 1 = fall-through). Changing it after reset has no effect on behaviour until the next reset.
- R2: After a reset in standard mode, `in_flag` = 1 and `out_flag` = 0. After a reset in fall-through mode, `in_flag` = 0 and `out_flag` = 1. In both modes `rd_data` is 0.
- R3: In standard mode a written word does not reach `rd_data` without a read. `rd_data` changes only on an edge where `rd_en` is high and the FIFO holds a word, and it shows the head word right after that edge.
- R4: In standard mode `out_flag` goes to 1 right after the edge that writes the first word, and goes back to 0 right after the edge that reads the last word. `in_flag` goes to 0 right after the edge that stores the DEPTH-th word.
- R5: In fall-through mode a word written into an empty FIFO on clock edge k appears on `rd_data`, with `out_flag` = 0, right after edge k+1, with no read requested.
- R6: In fall-through mode the capacity is DEPTH+1 words. `in_flag` stays 0 through DEPTH writes and goes to 1 right after the edge of write DEPTH+1, when no reads have been made.
- R7: In fall-through mode, a read of the last word sets `out_flag` to 1 right after that edge, and `rd_data` keeps the last word.
- R8: A write requested while the FIFO is full changes neither the stored words nor the pointers. Later reads return only the words stored before it.
- R9: A read requested while the FIFO is empty leaves `rd_data` and both flags unchanged.
- R10: The first read from a full FIFO releases the full indication right after its edge: `in_flag` goes to 1 in standard mode and to 0 in fall-through mode.
- R11: A simultaneous read and write while the FIFO is neither full nor empty keeps the word count unchanged.
- R12: Words leave in the order they were written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 1 | Timing mode select, sampled while `rst` is high (0 standard, 1 fall-through) |
| wr_en | input | 1 | Write request |
| wr_data | input | 18 | Word to write |
| rd_en | input | 1 | Read request |
| rd_data | output | 18 | Output register |
| in_flag | output | 1 | Standard: full, active low. Fall-through: input not ready, high when full |
| out_flag | output | 1 | Standard: empty, active low. Fall-through: output not valid, high when empty |

## Verification
Every result is due one edge after the stimulus that causes it. The flags and `rd_data` in standard mode, and the flags after a read in fall-through mode, reflect the state that edge produced. The exception is a fall-through write into an empty buffer: its word and `out_flag` = 0 arrive one edge later, at edge k+1. The bench drives inputs on the falling edge, lets exactly one rising edge pass, and samples on the next falling edge. The fall-through first-word check therefore looks once after the write edge, expecting the old output, and again after the following edge, expecting the new word. Full and empty corners are reached by counting writes and reads against a bench-side queue, so each flag transition is checked on the exact edge of the write or read that causes it.

// File: rtl/dmf_pkg.sv
package dmf_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } fifo_mode_e;
endpackage

// File: rtl/dmf_store.sv
// Simple dual-port storage array, written so a block RAM can be inferred:
// one synchronous write port and one registered read port with enable.
module dmf_store #(
  parameter int DW    = 18,
  parameter int DEPTH = 256,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dmf_ctrl.sv
// Pointer and occupancy tracking for the storage array.
module dmf_ctrl #(
  parameter int DEPTH = 256,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [CW-1:0] count,
  output logic [CW-1:0] count_nx,
  output logic          arr_full,
  output logic          arr_empty
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign count_nx  = count + CW'(push) - CW'(pop);
  assign arr_full  = (count == CW'(DEPTH));
  assign arr_empty = (count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= bump(wptr);
      if (pop)  rptr <= bump(rptr);
      count <= count_nx;
    end
  end

  // R8: a push into a full array is only legal when a pop frees a slot
  a_r8_push_needs_room: assert property (@(posedge clk) disable iff (rst)
    (push && arr_full) |-> pop);
  // R9: never pop an empty array
  a_r9_no_pop_empty: assert property (@(posedge clk) disable iff (rst)
    pop |-> !arr_empty);
  // R11: simultaneous push and pop keep the count
  a_r11_count_hold: assert property (@(posedge clk) disable iff (rst)
    (push && pop) |=> $stable(count));
  // R6: occupancy never exceeds the array depth
  a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
endmodule

// File: rtl/dmf_flags.sv
// Registered boundary flags; encoding depends on the latched timing mode.
module dmf_flags #(
  parameter int DEPTH = 256,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_sel,
  input  logic          fwft,
  input  logic [CW-1:0] count_nx,
  input  logic          ovalid_nx,
  output logic          in_flag,
  output logic          out_flag
);
  logic arr_full_nx;
  assign arr_full_nx = (count_nx == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      in_flag  <= !mode_sel;
      out_flag <= mode_sel;
    end else if (fwft) begin
      in_flag  <= arr_full_nx && ovalid_nx;
      out_flag <= !ovalid_nx;
    end else begin
      in_flag  <= !arr_full_nx;
      out_flag <= (count_nx != '0);
    end
  end
endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo
  import dmf_pkg::*;
#(
  parameter int DW    = 18,
  parameter int DEPTH = 256,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_sel,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          in_flag,
  output logic          out_flag
);
  fifo_mode_e    mode_q;
  logic          fwft;
  logic          ovalid, ovalid_nx;
  logic          push, pop, full_now;
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count, count_nx;
  logic          arr_full, arr_empty;

  // Mode is captured only while reset is held
  always_ff @(posedge clk) begin
    if (rst) mode_q <= fifo_mode_e'(mode_sel);
  end
  assign fwft = (mode_q == MODE_FWFT);

  // In fall-through mode the output register is an extra storage stage
  assign full_now = fwft ? (arr_full && ovalid) : arr_full;
  assign push     = !rst && wr_en && !full_now;
  assign pop      = !rst && !arr_empty && (fwft ? (!ovalid || rd_en) : rd_en);

  always_comb begin
    ovalid_nx = ovalid;
    if (!fwft)                 ovalid_nx = 1'b0;
    else if (pop)              ovalid_nx = 1'b1;
    else if (rd_en && ovalid)  ovalid_nx = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) ovalid <= 1'b0;
    else     ovalid <= ovalid_nx;
  end

  dmf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .wptr(wptr), .rptr(rptr), .count(count), .count_nx(count_nx),
    .arr_full(arr_full), .arr_empty(arr_empty)
  );

  dmf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .we(push), .waddr(wptr), .wdata(wr_data),
    .re(pop), .raddr(rptr), .rdata(rd_data)
  );

  dmf_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .fwft(fwft),
    .count_nx(count_nx), .ovalid_nx(ovalid_nx),
    .in_flag(in_flag), .out_flag(out_flag)
  );

  // R1: mode register only moves under reset
  a_r1_mode_stable: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(mode_q));
  // R3: standard mode output holds without a read request
  a_r3_std_hold: assert property (@(posedge clk) disable iff (rst)
    (!fwft && !rd_en) |=> $stable(rd_data));
  // R9: standard mode read while empty changes nothing at the output
  a_r9_empty_read_hold: assert property (@(posedge clk) disable iff (rst)
    (!fwft && !out_flag && !wr_en) |=> ($stable(rd_data) && !out_flag));
  // R4: standard full stays asserted while only writes arrive
  a_r4_std_full_sticky: assert property (@(posedge clk) disable iff (rst)
    (!fwft && !in_flag && !rd_en) |=> !in_flag);
  // R7: fall-through output-not-valid flag tracks the output stage
  a_r7_fwft_valid: assert property (@(posedge clk) disable iff (rst)
    fwft |-> (out_flag == !ovalid));
endmodule

// File: tb/sim_dual_mode_fifo.sv
`timescale 1ns/1ps
module sim_dual_mode_fifo;
  localparam int DW    = 18;
  localparam int DEPTH = 16;

  logic          clk = 1'b0;
  logic          rst, mode_sel, wr_en, rd_en;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] rd_data;
  logic          in_flag, out_flag;

  int n_total = 0;
  int n_fail  = 0;
  logic [DW-1:0] q[$];

  always #2.5 clk = ~clk;

  dual_mode_fifo #(.DW(DW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .in_flag(in_flag), .out_flag(out_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One clock cycle: drive at falling edge, pass one rising edge, return at falling edge
  task automatic cyc(input logic we, input logic [DW-1:0] wd, input logic re);
    wr_en = we; wr_data = wd; rd_en = re;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic do_reset(input logic m);
    @(negedge clk);
    rst = 1'b1; mode_sel = m; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    q.delete();
  endtask

  task automatic t_reset_state();
    do_reset(1'b0);
    chk("R2 std in_flag", in_flag, 1);
    chk("R2 std out_flag", out_flag, 0);
    chk("R2 std rd_data", rd_data, 0);
    do_reset(1'b1);
    chk("R2 fwft in_flag", in_flag, 0);
    chk("R2 fwft out_flag", out_flag, 1);
    chk("R2 fwft rd_data", rd_data, 0);
  endtask

  task automatic t_std_basic();
    do_reset(1'b0);
    cyc(1'b1, 18'h2A5A5, 1'b0);
    chk("R4 out_flag after first write", out_flag, 1);
    chk("R3 word not on output", rd_data, 0);
    cyc(1'b0, '0, 1'b0);
    chk("R3 word still off output", rd_data, 0);
    cyc(1'b0, '0, 1'b1);
    chk("R3 word after read", rd_data, 18'h2A5A5);
    chk("R4 out_flag after last read", out_flag, 0);
    cyc(1'b0, '0, 1'b1);
    chk("R9 std empty read data", rd_data, 18'h2A5A5);
    chk("R9 std empty read flag", out_flag, 0);
    chk("R9 std empty read in_flag", in_flag, 1);
  endtask

  task automatic t_std_full();
    do_reset(1'b0);
    for (int i = 0; i < DEPTH; i++) begin
      if (i == DEPTH - 1) chk("R4 in_flag before last write", in_flag, 1);
      cyc(1'b1, DW'(18'h100 + i), 1'b0);
    end
    chk("R4 in_flag full", in_flag, 0);
    cyc(1'b1, 18'h3FFFF, 1'b0);
    chk("R8 full stays after dropped write", in_flag, 0);
    cyc(1'b0, '0, 1'b1);
    chk("R10 std full released", in_flag, 1);
    chk("R12 std first word", rd_data, 18'h100);
    for (int i = 1; i < DEPTH; i++) begin
      cyc(1'b0, '0, 1'b1);
      chk("R12 std order", rd_data, 32'(18'h100 + i));
    end
    chk("R4 out_flag empty after drain", out_flag, 0);
    cyc(1'b0, '0, 1'b1);
    chk("R8 dropped word never read", rd_data, 32'(18'h100 + DEPTH - 1));
  endtask

  task automatic t_std_simul();
    logic [DW-1:0] v;
    do_reset(1'b0);
    for (int i = 0; i < 3; i++) begin
      v = DW'(18'h3000 + i); q.push_back(v); cyc(1'b1, v, 1'b0);
    end
    for (int i = 0; i < 5; i++) begin
      v = DW'(18'h3100 + i); q.push_back(v);
      cyc(1'b1, v, 1'b1);
      chk("R11 simultaneous read data", rd_data, q.pop_front());
    end
    for (int i = 0; i < DEPTH - 3; i++) begin
      if (i == DEPTH - 4) chk("R11 not full one short", in_flag, 1);
      v = DW'(18'h3200 + i); q.push_back(v); cyc(1'b1, v, 1'b0);
    end
    chk("R11 full after count restored", in_flag, 0);
    while (q.size() > 0) begin
      cyc(1'b0, '0, 1'b1);
      chk("R12 drain order", rd_data, q.pop_front());
    end
  endtask

  task automatic t_fwft_basic();
    do_reset(1'b1);
    cyc(1'b1, 18'h15555, 1'b0);
    chk("R5 not yet on output (edge k)", rd_data, 0);
    chk("R5 not yet valid (edge k)", out_flag, 1);
    cyc(1'b0, '0, 1'b0);
    chk("R5 word on output (edge k+1)", rd_data, 18'h15555);
    chk("R5 output valid", out_flag, 0);
    cyc(1'b0, '0, 1'b1);
    chk("R7 out_flag after last read", out_flag, 1);
    chk("R7 data held", rd_data, 18'h15555);
    cyc(1'b0, '0, 1'b1);
    chk("R9 fwft empty read data", rd_data, 18'h15555);
    chk("R9 fwft empty read flag", out_flag, 1);
    chk("R9 fwft empty read in_flag", in_flag, 0);
  endtask

  task automatic t_fwft_full();
    do_reset(1'b1);
    for (int i = 0; i <= DEPTH; i++) begin
      if (i == DEPTH) chk("R6 ready after DEPTH writes", in_flag, 0);
      cyc(1'b1, DW'(18'h500 + i), 1'b0);
    end
    chk("R6 not ready after DEPTH+1 writes", in_flag, 1);
    chk("R12 fwft head word", rd_data, 18'h500);
    cyc(1'b1, 18'h3FFFF, 1'b0);
    chk("R8 fwft dropped write", in_flag, 1);
    cyc(1'b0, '0, 1'b1);
    chk("R10 fwft full released", in_flag, 0);
    chk("R12 fwft second word", rd_data, 18'h501);
    for (int i = 2; i <= DEPTH; i++) begin
      cyc(1'b0, '0, 1'b1);
      chk("R12 fwft order", rd_data, 32'(18'h500 + i));
    end
    chk("R7 still valid before final read", out_flag, 0);
    cyc(1'b0, '0, 1'b1);
    chk("R7 empty after final read", out_flag, 1);
    chk("R8 fwft dropped word never shown", rd_data, 32'(18'h500 + DEPTH));
  endtask

  task automatic t_mode_latch();
    do_reset(1'b0);
    mode_sel = 1'b1;
    cyc(1'b1, 18'h0ABCD, 1'b0);
    cyc(1'b0, '0, 1'b0);
    chk("R1 mode ignored after reset data", rd_data, 0);
    chk("R1 mode ignored after reset flag", out_flag, 1);
    cyc(1'b0, '0, 1'b1);
    chk("R1 standard read still works", rd_data, 18'h0ABCD);
  endtask

  initial begin
    rst = 1'b1; mode_sel = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    t_reset_state();
    t_std_basic();
    t_std_full();
    t_std_simul();
    t_fwft_basic();
    t_fwft_full();
    t_mode_latch();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_total++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule